// File: doc/BRIEF.md
# Coprocessor Privilege-Checking Handshake Responder

This block is the instruction-side front end of an external coprocessor that sits beside a pipelined CPU. Each cycle the CPU may present a fetched instruction word and a privilege flag, where low means a user-mode instruction and high means a privileged-mode one. The block latches both together and moves them down a short internal pipeline. When the pair reaches the decode stage, the block decides whether to claim the instruction. To be claimed, the word must be a coprocessor instruction aimed at this block's coprocessor number. Its opcode must be one the block implements. If that opcode is reserved for privileged code, the flag that travelled with the word must be high.

The verdict is driven on two handshake lines. Both low means "accepted". Both high means "no coprocessor takes this", and the CPU then takes its undefined-instruction trap. A privilege violation therefore looks to the CPU exactly like a missing coprocessor. For claimed instructions that move data toward the CPU, the block raises its data-bus enable. Each claimed instruction's operand fields are loaded into a small operation register for the datapath behind it. A flush input empties the pipeline.

Top module: `cop_front_end`

## Requirements
- R1: A word is a candidate only if its bits [27:24] equal 4'hE, its bits [11:8] equal the parameter CP_ID, and its bits [31:28] are not 4'hF. Any other word, valid or not, gets the both-high response.
- R2: A candidate whose opcode field, bits [23:20], indexes a zero bit of IMPL_MASK is rejected with both lines high.
- R3: A candidate presented with the privilege flag low whose opcode indexes a set bit of PRIV_MASK is rejected with both lines high.
- R4: Any other candidate is accepted. Both lines go low after the PIPE_DEPTH-th rising edge following the cycle it was presented (2 with defaults) and stay low for one cycle.
- R5: Whenever the decode stage holds no accepted instruction, both handshake lines are high. The lines are never split.
- R6: The privilege flag is taken in the same cycle as the word and travels with it. A change on the flag input after that cycle does not alter the verdict.
- R7: The data-bus enable is high exactly when the decode stage holds an accepted instruction with bit 20 = 1 and bit 4 = 1. Otherwise it is low.
- R8: On the rising edge that ends a cycle with an accepted instruction in decode and no flush, the operation register loads opc = bits [23:20], crn = [19:16], crd = [15:12], aux = [7:5] and crm = [3:0]. Otherwise it holds its value.
- R9: A flush discards every instruction in the pipeline at that edge. After it, both lines are high, the enable is low, and the operation register does not load.
- R10: While reset is high, both lines are high, the enable is low and the operation register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all instructions in the pipeline |
| in_valid | input | 1 | An instruction word is presented this cycle |
| in_word | input | 32 | Instruction word |
| in_priv | input | 1 | Privilege of the presented word (1 = privileged) |
| hs_line_a | output | 1 | Handshake line A (low with B = accept) |
| hs_line_b | output | 1 | Handshake line B (high with A = absent/reject) |
| bus_oe | output | 1 | Data-bus enable toward the CPU |
| op_opc | output | 4 | Operation register: opcode |
| op_crn | output | 4 | Operation register: first source register |
| op_crd | output | 4 | Operation register: destination register |
| op_aux | output | 3 | Operation register: auxiliary opcode |
| op_crm | output | 4 | Operation register: second source register |

## Verification
A word presented in one cycle gets its handshake verdict and bus enable two rising edges later. Its operation-register update is visible one edge after that. The bench drives each word on a falling edge and checks the lines and the enable on the second falling edge after that. It then checks the operation register, and the return of both lines to high, on the third falling edge. The sweep covers every opcode under both privilege values, both bit-4 settings, a matching and a foreign coprocessor number, every class nibble and the reserved condition value. The privilege input is inverted right after capture so that its late value can never satisfy a check. Back-to-back words with a flush check that the second verdict and the register load are dropped.

// File: rtl/cop_fe_pkg.sv
package cop_fe_pkg;

    localparam int WORD_W   = 32;
    localparam int OPC_W    = 4;
    localparam int NUM_OPC  = 1 << OPC_W;
    localparam int REG_W    = 4;
    localparam int AUX_W    = 3;

    localparam logic [3:0] CP_CLASS   = 4'hE;
    localparam logic [3:0] COND_NEVER = 4'hF;

    typedef struct packed {
        logic              valid;
        logic              priv;
        logic [WORD_W-1:0] word;
    } slot_t;

    typedef enum logic [1:0] {
        RESP_ACCEPT = 2'b00,
        RESP_ABSENT = 2'b11
    } resp_e;

    typedef struct packed {
        logic  accept;
        logic  to_cpu;
        resp_e resp;
    } verdict_t;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [REG_W-1:0] crn;
        logic [REG_W-1:0] crd;
        logic [AUX_W-1:0] aux;
        logic [REG_W-1:0] crm;
    } op_fields_t;

    function automatic logic [OPC_W-1:0] opc_of(input logic [WORD_W-1:0] w);
        return w[23:20];
    endfunction

    function automatic logic is_cp_form(input logic [WORD_W-1:0] w,
                                        input logic [3:0] cp_id);
        return (w[31:28] != COND_NEVER) && (w[27:24] == CP_CLASS) &&
               (w[11:8] == cp_id);
    endfunction

    function automatic op_fields_t fields_of(input logic [WORD_W-1:0] w);
        op_fields_t f;
        f.opc = w[23:20];
        f.crn = w[19:16];
        f.crd = w[15:12];
        f.aux = w[7:5];
        f.crm = w[3:0];
        return f;
    endfunction

endpackage

// File: rtl/cop_pipe_stage.sv
module cop_pipe_stage
    import cop_fe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  slot_t d,
    output slot_t q
);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/cop_decide.sv
module cop_decide
    import cop_fe_pkg::*;
#(
    parameter logic [3:0]         CP_ID     = 4'd5,
    parameter logic [NUM_OPC-1:0] IMPL_MASK = 16'hF3F7,
    parameter logic [NUM_OPC-1:0] PRIV_MASK = 16'h5238
) (
    input  slot_t    slot,
    output verdict_t verdict
);

    logic             hit;
    logic             implemented;
    logic             allowed;
    logic [OPC_W-1:0] opc;

    always_comb begin
        opc         = opc_of(slot.word);
        hit         = slot.valid && is_cp_form(slot.word, CP_ID);
        implemented = IMPL_MASK[opc];
        allowed     = slot.priv || !PRIV_MASK[opc];

        verdict.accept = hit && implemented && allowed;
        verdict.to_cpu = verdict.accept && slot.word[20] && slot.word[4];
        verdict.resp   = verdict.accept ? RESP_ACCEPT : RESP_ABSENT;
    end

endmodule

// File: rtl/cop_opreg.sv
module cop_opreg
    import cop_fe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  op_fields_t d,
    output op_fields_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

    // R8: without a load the register keeps its value
    a_r8_hold_without_load: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));

endmodule

// File: rtl/cop_front_end.sv
module cop_front_end
    import cop_fe_pkg::*;
#(
    parameter logic [3:0]         CP_ID      = 4'd5,
    parameter logic [NUM_OPC-1:0] IMPL_MASK  = 16'hF3F7,
    parameter logic [NUM_OPC-1:0] PRIV_MASK  = 16'h5238,
    parameter int                 PIPE_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_priv,
    output logic              hs_line_a,
    output logic              hs_line_b,
    output logic              bus_oe,
    output logic [OPC_W-1:0]  op_opc,
    output logic [REG_W-1:0]  op_crn,
    output logic [REG_W-1:0]  op_crd,
    output logic [AUX_W-1:0]  op_aux,
    output logic [REG_W-1:0]  op_crm
);

    localparam int DEC_IDX = PIPE_DEPTH;

    slot_t      chain [0:PIPE_DEPTH];
    slot_t      dec_slot;
    verdict_t   verdict;
    op_fields_t op_q;
    logic       op_load;

    // privilege flag is bundled with the word at capture (R6)
    assign chain[0] = '{valid: in_valid, priv: in_priv, word: in_word};

    for (genvar s = 0; s < PIPE_DEPTH; s++) begin : g_stage
        cop_pipe_stage u_stage (
            .clk   (clk),
            .rst   (rst),
            .flush (flush),
            .d     (chain[s]),
            .q     (chain[s+1])
        );
    end

    assign dec_slot = chain[DEC_IDX];

    cop_decide #(
        .CP_ID     (CP_ID),
        .IMPL_MASK (IMPL_MASK),
        .PRIV_MASK (PRIV_MASK)
    ) u_decide (
        .slot    (dec_slot),
        .verdict (verdict)
    );

    assign {hs_line_a, hs_line_b} = verdict.resp;
    assign bus_oe                 = verdict.to_cpu;
    assign op_load                = verdict.accept && !flush;

    cop_opreg u_opreg (
        .clk  (clk),
        .rst  (rst),
        .load (op_load),
        .d    (fields_of(dec_slot.word)),
        .q    (op_q)
    );

    assign op_opc = op_q.opc;
    assign op_crn = op_q.crn;
    assign op_crd = op_q.crd;
    assign op_aux = op_q.aux;
    assign op_crm = op_q.crm;

    // R4: an accept response needs an occupied decode stage
    a_r4_accept_needs_slot: assert property (@(posedge clk) disable iff (rst)
        (!hs_line_a || !hs_line_b) |-> dec_slot.valid);

    // R5: the two lines always carry the same level
    a_r5_lines_agree: assert property (@(posedge clk) disable iff (rst)
        hs_line_a == hs_line_b);

    // R3: a user-mode word on a privileged opcode is never accepted
    a_r3_user_blocked: assert property (@(posedge clk) disable iff (rst)
        (dec_slot.valid && !dec_slot.priv && PRIV_MASK[opc_of(dec_slot.word)])
        |-> (hs_line_a && hs_line_b));

    // R7: data-bus enable only alongside an accept
    a_r7_oe_with_accept: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> (!hs_line_a && !hs_line_b));

    // R9: after a flush the pipeline is empty
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (hs_line_a && hs_line_b && !bus_oe));

endmodule

// File: tb/cop_front_end_tb.sv
module cop_front_end_tb;

    localparam logic [3:0]  CP   = 4'd5;
    localparam logic [3:0]  CP_X = 4'd9;
    localparam logic [15:0] IMPL = 16'hF3F7;
    localparam logic [15:0] PRIV = 16'h5238;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_priv = 1'b0;
    logic        hs_line_a, hs_line_b, bus_oe;
    logic [3:0]  op_opc, op_crn, op_crd, op_crm;
    logic [2:0]  op_aux;

    int n_cmp = 0;
    int n_bad = 0;
    logic [18:0] exp_op = '0;

    always #10 clk = ~clk;

    cop_front_end #(
        .CP_ID (CP), .IMPL_MASK (IMPL), .PRIV_MASK (PRIV), .PIPE_DEPTH (2)
    ) u_dut (
        .clk (clk), .rst (rst), .flush (flush), .in_valid (in_valid),
        .in_word (in_word), .in_priv (in_priv), .hs_line_a (hs_line_a),
        .hs_line_b (hs_line_b), .bus_oe (bus_oe), .op_opc (op_opc),
        .op_crn (op_crn), .op_crd (op_crd), .op_aux (op_aux), .op_crm (op_crm)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    function automatic logic [31:0] mk(input logic [3:0] cond, input logic [3:0] cls,
                                       input logic [3:0] opc, input logic [3:0] crn,
                                       input logic [3:0] crd, input logic [3:0] cp,
                                       input logic [2:0] aux, input logic b4,
                                       input logic [3:0] crm);
        return {cond, cls, opc, crn, crd, cp, aux, b4, crm};
    endfunction

    function automatic logic want(input logic [31:0] w, input logic p);
        logic form;
        form = (w[31:28] != 4'hF) && (w[27:24] == 4'hE) && (w[11:8] == CP);
        return form && IMPL[w[23:20]] && (p || !PRIV[w[23:20]]);
    endfunction

    function automatic string why(input logic [31:0] w, input logic p);
        if (!((w[31:28] != 4'hF) && (w[27:24] == 4'hE) && (w[11:8] == CP))) return "R1";
        if (!IMPL[w[23:20]]) return "R2";
        if (!p && PRIV[w[23:20]]) return "R3";
        return PRIV[w[23:20]] ? "R4/R6" : "R4";
    endfunction

    function automatic logic [18:0] flds(input logic [31:0] w);
        return {w[23:20], w[19:16], w[15:12], w[7:5], w[3:0]};
    endfunction

    // present one word, flip privilege after capture (R6), check verdict and register
    task automatic send(input logic [31:0] w, input logic p);
        logic acc;
        acc = want(w, p);
        @(negedge clk); in_valid = 1'b1; in_word = w; in_priv = p;
        @(negedge clk); in_valid = 1'b0; in_word = ~w; in_priv = ~p;
        @(negedge clk);
        check(why(w, p), {30'd0, hs_line_a, hs_line_b}, acc ? 32'd0 : 32'd3);
        check("R7", {31'd0, bus_oe}, {31'd0, acc && w[20] && w[4]});
        @(negedge clk);
        if (acc) exp_op = flds(w);
        check("R8", {13'd0, op_opc, op_crn, op_crd, op_aux, op_crm}, {13'd0, exp_op});
        check("R5", {30'd0, hs_line_a, hs_line_b}, 32'd3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", {30'd0, hs_line_a, hs_line_b}, 32'd3);
        check("R10", {31'd0, bus_oe}, 32'd0);
        check("R10", {13'd0, op_opc, op_crn, op_crd, op_aux, op_crm}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R5", {30'd0, hs_line_a, hs_line_b}, 32'd3);

        // opcode x privilege x bit4 x coprocessor number sweep (R1..R8)
        for (int c = 0; c < 2; c++)
            for (int o = 0; o < 16; o++)
                for (int p = 0; p < 2; p++)
                    for (int b = 0; b < 2; b++)
                        send(mk(4'hE, 4'hE, 4'(o), 4'(o + 3), 4'(15 - o),
                                (c == 0) ? CP : CP_X, 3'(o + p), b[0], 4'(o ^ 5)),
                             p[0]);

        // every class nibble with an unprivileged implemented opcode (R1)
        for (int k = 0; k < 16; k++)
            send(mk(4'h1, 4'(k), 4'h1, 4'h2, 4'h3, CP, 3'd4, 1'b1, 4'(k)), 1'b0);

        // reserved condition value is not a candidate (R1)
        send(mk(4'hF, 4'hE, 4'h1, 4'h6, 4'h7, CP, 3'd1, 1'b0, 4'h8), 1'b1);

        // R9: flush while one word is in decode and a second in the first stage
        @(negedge clk); in_valid = 1'b1; in_priv = 1'b1;
        in_word = mk(4'h0, 4'hE, 4'h1, 4'hA, 4'hB, CP, 3'd2, 1'b1, 4'hC);
        @(negedge clk);
        in_word = mk(4'h0, 4'hE, 4'h0, 4'h9, 4'h8, CP, 3'd3, 1'b0, 4'h7);
        @(negedge clk); in_valid = 1'b0;
        check("R4", {30'd0, hs_line_a, hs_line_b}, 32'd0);
        check("R7", {31'd0, bus_oe}, 32'd1);
        flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        check("R9", {30'd0, hs_line_a, hs_line_b}, 32'd3);
        check("R9", {31'd0, bus_oe}, 32'd0);
        check("R9", {13'd0, op_opc, op_crn, op_crd, op_aux, op_crm}, {13'd0, exp_op});
        @(negedge clk);
        check("R9", {30'd0, hs_line_a, hs_line_b}, 32'd3);

        // R9: flush while a word is only in the first stage
        @(negedge clk); in_valid = 1'b1; in_priv = 1'b1;
        in_word = mk(4'h0, 4'hE, 4'h2, 4'h1, 4'h1, CP, 3'd0, 1'b0, 4'h1);
        @(negedge clk); in_valid = 1'b0; flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        check("R9", {30'd0, hs_line_a, hs_line_b}, 32'd3);
        @(negedge clk);
        check("R9", {13'd0, op_opc, op_crn, op_crd, op_aux, op_crm}, {13'd0, exp_op});

        summary();
        $finish;
    end

endmodule